// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes a stereo serial audio stream made of a bit clock, a word-select line and a data line, and turns it into parallel left/right sample pairs of 24-bit two's-complement data. All three serial lines are brought into the system clock domain through two-flop synchronisers. Rising bit-clock edges and word-select changes are then found by comparing the synchronised values with their previous samples. No serial line is used as a clock.

A static format input picks the framing. In MSB-justified framing the most significant bit sits in the first bit slot after a word-select change. In I2S framing it sits one slot later. Each channel slot carries one word. Bits past the 24th are discarded, and words cut short are padded with zeros at the LSB end. When the word select changes at the start of a new frame, the finished left and right words are presented together with a one-cycle valid strobe. They stay on the outputs until the next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low and after its release, valid_o is 0 and left_o/right_o are all zeros until the first pair is delivered.
- R2: With fmt_i = 0 (MSB-justified), ws_i = 1 marks the left channel. The bit sampled on the first rising bit-clock edge after a ws_i change is bit 23 (MSB) of the new word, and later edges give bits 22 down to 0.
- R3: With fmt_i = 1 (I2S), ws_i = 0 marks the left channel. The first rising edge after a ws_i change still carries a bit of the previous word, and the second edge carries bit 23 of the new word.
- R4: Within one channel slot only the first 24 data bits are kept. Any further bits in that slot have no effect on the delivered word.
- R5: If a channel slot ends after fewer than 24 data bits, the bits received fill the word from bit 23 downward and the missing low bits are 0.
- R6: valid_o pulses high for exactly one cycle for each frame, after the ws_i change that ends the right-channel word. A word is only delivered if it began at a ws_i change and a left word preceded it, so the partial word seen after reset is dropped.
- R7: left_o and right_o change only together with a valid_o pulse and otherwise hold their values.
- R8: Frames of 48 bit-clock cycles (exactly 24 slots per channel) are received in full in both formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, fast enough to oversample the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | Framing select: 0 MSB-justified, 1 I2S; held static |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select, changes on falling bit-clock edges |
| sd_i | input | 1 | Serial data, MSB first, changes on falling bit-clock edges |
| left_o | output | WORD_W (24) | Left-channel sample of the last delivered pair |
| right_o | output | WORD_W (24) | Right-channel sample of the last delivered pair |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
Wrong internal state has distinct symptoms at the ports:
- **Slot count off by one:** every word comes out shifted by one bit on its first delivery. The extreme words 0x800000 and 0x7FFFFF expose this at once.
- **Channel level flipped:** left and right appear swapped within the first frame.
- **Arming or pairing state wrong:** an unexpected strobe appears during the lead-in, or an expected strobe is missing at the end of a sequence.

Short and overlong slots are checked by filling unused positions with ones. A word that picks up a trailing bit then shows a wrong low byte in the very pair that contains it.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic {
    FMT_MSBJ = 1'b0,
    FMT_I2S  = 1'b1
  } sarx_fmt_e;

  localparam int unsigned SARX_SYNC_STAGES = 2;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sarx_edge.sv
module sarx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  output logic rise_o,
  output logic ws_chg_o,
  output logic ws_prev_o
);
  logic sck_d, ws_q, started_q;

  assign rise_o    = sck_i & ~sck_d;
  // first rise only records the level; it is never a change
  assign ws_chg_o  = rise_o & started_q & (ws_i != ws_q);
  assign ws_prev_o = ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d     <= 1'b0;
      ws_q      <= 1'b0;
      started_q <= 1'b0;
    end else begin
      sck_d <= sck_i;
      if (rise_o) begin
        ws_q      <= ws_i;
        started_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              i2s_i,
  input  logic              rise_i,
  input  logic              ws_chg_i,
  input  logic              sd_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam int unsigned IDX_W   = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  logic [CNT_W-1:0]  cnt_q, pos;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc_q, acc_upd;
  logic              armed_q, in_old, own_old;

  // slot count continues into the edge slot; I2S shifts data one slot late
  assign pos     = cnt_q - CNT_W'(i2s_i);
  assign in_old  = (cnt_q >= CNT_W'(i2s_i)) && (pos < CNT_W'(WORD_W));
  assign idx     = IDX_W'(WORD_W - 1) - IDX_W'(pos);
  // in I2S the edge slot still belongs to the word being closed
  assign own_old = !ws_chg_i || i2s_i;

  always_comb begin
    acc_upd = acc_q;
    if (rise_i && own_old && in_old) acc_upd[idx] = sd_i;
  end

  assign done_o = ws_chg_i & armed_q;
  assign word_o = acc_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      if (ws_chg_i) begin
        acc_q   <= {sd_i & ~i2s_i, {(WORD_W-1){1'b0}}};
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b1;
      end else begin
        acc_q <= acc_upd;
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic              sck_s, ws_s, sd_s;
  logic              bit_rise, ws_chg, ws_prev, word_done, is_i2s, old_is_left;
  logic              have_left_q;
  logic [WORD_W-1:0] word, left_hold_q;

  assign is_i2s = (fmt_i == FMT_I2S);

  sarx_sync #(.W(3), .STAGES(SARX_SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   ({sck_s, ws_s, sd_s})
  );

  sarx_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_s),
    .ws_i     (ws_s),
    .rise_o   (bit_rise),
    .ws_chg_o (ws_chg),
    .ws_prev_o(ws_prev)
  );

  sarx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .i2s_i   (is_i2s),
    .rise_i  (bit_rise),
    .ws_chg_i(ws_chg),
    .sd_i    (sd_s),
    .done_o  (word_done),
    .word_o  (word)
  );

  // left level: high in MSB-justified, low in I2S
  assign old_is_left = is_i2s ? ~ws_prev : ws_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      left_hold_q <= '0;
      have_left_q <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_done) begin
        if (old_is_left) begin
          left_hold_q <= word;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= left_hold_q;
          right_o     <= word;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
  parameter int unsigned WORD_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              bit_rise,
  input logic              ws_chg
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6

  AST_VALID_AFTER_WS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(ws_chg)); // R6

  AST_OUTPUTS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7

  AST_WS_CHANGE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ws_chg |-> bit_rise); // R2

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_rise |=> !bit_rise); // R3
endmodule

bind serial_audio_rx sarx_chk #(.WORD_W(WORD_W)) u_sarx_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_o (valid_o),
  .left_o  (left_o),
  .right_o (right_o),
  .bit_rise(bit_rise),
  .ws_chg  (ws_chg)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;
  localparam int W = 24;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         fmt_i = 1'b0;
  logic         sck_i = 1'b0;
  logic         ws_i = 1'b0;
  logic         sd_i = 1'b0;
  logic [W-1:0] left_o, right_o;
  logic         valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_pulse = 0;
  bit done = 0;

  logic [2*W-1:0] exp_q[$];
  string          tag_q[$];

  always #4 clk_i = ~clk_i;

  serial_audio_rx #(.WORD_W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .fmt_i(fmt_i), .sck_i(sck_i),
    .ws_i(ws_i), .sd_i(sd_i), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare every delivered pair
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      n_pulse++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected pair", {left_o, right_o}, '0);
      end else begin
        logic [2*W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({left_o, right_o} === e, t, {left_o, right_o}, e);
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    sck_i  = 1'b0;
    repeat (4) @(negedge clk_i);
    check(valid_o === 1'b0 && left_o === '0 && right_o === '0, "R1 reset state",
          {left_o, right_o}, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(valid_o === 1'b0 && left_o === '0 && right_o === '0, "R1 after release",
          {left_o, right_o}, '0);
  endtask

  // driver: build the slot stream, push expected pairs, then play it
  task automatic run_seq(input logic fmt, input int half, input int nfr, input string tag);
    logic wsb[$];
    logic sdb[$];
    logic lvl;
    logic [W-1:0] mask;
    int   start_pulses;
    logic [2*W-1:0] last;
    lvl  = fmt ? 1'b0 : 1'b1;
    mask = (half >= W) ? '1 : ~((W'(1) << (W - half)) - W'(1));
    fmt_i = fmt;
    do_reset();
    start_pulses = n_pulse;
    last = '0;
    for (int k = 0; k < 8; k++) begin wsb.push_back(~lvl); sdb.push_back(1'b1); end
    for (int f = 0; f < nfr; f++) begin
      logic [W-1:0] l, r;
      l = (f == 0) ? 24'h800000 : W'($urandom);
      r = (f == 0) ? 24'h7FFFFF : W'($urandom);
      for (int ch = 0; ch < 2; ch++) begin
        logic [W-1:0] w;
        w = ch ? r : l;
        for (int k = 0; k < half; k++) begin
          wsb.push_back(ch ? ~lvl : lvl);
          sdb.push_back(k < W ? w[W-1-k] : 1'b1);
        end
      end
      last = {l & mask, r & mask};
      exp_q.push_back(last);
      tag_q.push_back(tag);
    end
    for (int k = 0; k < 4; k++) begin wsb.push_back(lvl); sdb.push_back(1'b0); end
    if (fmt) sdb.push_front(1'b1);
    for (int i = 0; i < wsb.size(); i++) begin
      sck_i = 1'b0; ws_i = wsb[i]; sd_i = sdb[i];
      repeat (4) @(negedge clk_i);
      sck_i = 1'b1;
      repeat (4) @(negedge clk_i);
    end
    sck_i = 1'b0;
    repeat (20) @(negedge clk_i);
    check(exp_q.size() == 0 && (n_pulse - start_pulses) == nfr, "R6 pulse count",
          48'(n_pulse - start_pulses), 48'(nfr));
    exp_q.delete();
    tag_q.delete();
    check({left_o, right_o} === last, "R7 outputs held", {left_o, right_o}, last);
  endtask

  initial begin
    run_seq(1'b0, 32, 3, "R2 R4 msb-justified 64fs");
    run_seq(1'b1, 32, 3, "R3 R4 i2s 64fs");
    run_seq(1'b0, 24, 2, "R8 msb-justified 48fs");
    run_seq(1'b1, 24, 2, "R8 R3 i2s 48fs");
    run_seq(1'b0, 16, 2, "R5 msb-justified short slot");
    run_seq(1'b1, 20, 2, "R5 i2s short slot");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule